// File: doc/BRIEF.md
# Vertical Field Timing Controller

This block tracks the field rhythm of an incoming video signal and produces a clean vertical sync pulse. It runs from a system clock at 432 times the line rate and counts enables that arrive at twice the line rate, so its counter works in half-lines. After 244 lines of each field, a norm classification supplied from outside sets how the counter may be cleared. With a strong norm the block makes the vertical sync itself. With a weak norm it accepts an input sync only inside a narrow window. With no norm it accepts any input sync, and a timeout clears the counter if none arrives.

The block has a 50 Hz side and a 60 Hz side. Every window and timeout on the 60 Hz side lies 100 half-lines earlier than on the 50 Hz side. A forced-mode input pins the side to a selected system. Otherwise the side follows the count at which the last accepted input sync was seen. The current count and side are outputs, together with the generated pulse.

Top module: `vfield_ctrl`

## Requirements
- R1: After reset the count is 0, the sync output is low, the system output is 0 (0 = 50 Hz, 1 = 60 Hz), and the controller is in its counting phase.
- R2: The count rises by one on each cycle with the double-rate enable high and holds otherwise. During the counting phase (count below 488) input sync edges have no effect.
- R3: When the count reaches 488 the norm input picks the branch: 2'b00 strong, 2'b01 weak, 2'b10 or 2'b11 none.
- R4: In the strong branch input syncs are ignored. The generated sync starts with the enable that brings the count to 622 (50 Hz) or 522 (60 Hz). The count stops at 626 (50 Hz) or 526 (60 Hz), and the next enable clears it to 0.
- R5: Every generated sync pulse stays high for exactly VS_LEN enables (default 6), counting the enable that starts it.
- R6: A rising edge of the input sync that is accepted clears the count on the next enable, half a line later, and a sync pulse starts with that enable.
- R7: In the weak branch an input edge is accepted only while the count is strictly between 622 and 628 (50 Hz) or between 522 and 528 (60 Hz). If no edge is accepted, the enable that would bring the count to 628 (50 Hz) or 528 (60 Hz) clears it instead and starts a sync pulse.
- R8: In the no-norm branch any input edge is accepted. With no edge, the timeout that clears the count (as in R7) is at 722 (50 Hz) or 622 (60 Hz) when both the forced flag and the lock flag are high, and at 628 (50 Hz) or 528 (60 Hz) otherwise.
- R9: The system output changes only when the count is cleared. When forced, it takes the forced select (1 = 60 Hz). In automatic mode, an accepted edge seen at a count below 575 selects 60 Hz and one at 575 or above selects 50 Hz, while timeouts and strong-branch clears leave the system unchanged.
- R10: An input edge that arrives in the same cycle as a timeout enable is discarded, so the count is cleared only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 432 times the line rate |
| rst | input | 1 | Synchronous active-high reset |
| en2h_i | input | 1 | Enable pulse at twice the line rate |
| vsync_in_i | input | 1 | Separated vertical sync from the video input |
| locked_i | input | 1 | Horizontal phase loop is locked |
| forced_i | input | 1 | Forced system mode |
| force60_i | input | 1 | System chosen in forced mode, 1 = 60 Hz |
| norm_i | input | 2 | Norm classification, 00 strong, 01 weak, 1x none |
| vsync_o | output | 1 | Generated vertical sync pulse |
| line_cnt_o | output | CNT_W | Half-line count in the current field |
| sys60_o | output | 1 | Current system, 1 = 60 Hz |

## Verification
Two events can land in the same clock edge: an input sync edge being accepted, and a timeout enable clearing the count. The bench provokes this by raising the input sync and the enable together at the last count before the 60 Hz weak-branch timeout. It then expects a single clear, with the count reading 1 after the following enable instead of a second return to 0. Random fields vary the norm, the lock and forced flags, and the sync position across and outside every window, and each one is scored against a bench function for the peak count and the resulting system.

// File: rtl/vfield_pkg.sv
package vfield_pkg;
  typedef enum logic [2:0] {
    PH_COUNT  = 3'd0,
    PH_STRONG = 3'd1,
    PH_WEAK   = 3'd2,
    PH_NONE   = 3'd3,
    PH_HOLD   = 3'd4
  } phase_t;

  localparam logic [1:0] NORM_STRONG = 2'b00;
  localparam logic [1:0] NORM_WEAK   = 2'b01;
endpackage

// File: rtl/vfield_edge.sv
module vfield_edge (
  input  logic clk,
  input  logic rst,
  input  logic sig_i,
  output logic rise_o
);
  logic sig_q;

  always_ff @(posedge clk) begin
    if (rst) sig_q <= 1'b0;
    else     sig_q <= sig_i;
  end

  assign rise_o = sig_i & ~sig_q;
endmodule

// File: rtl/vfield_limits.sv
module vfield_limits #(
  parameter int CNT_W      = 10,
  parameter int VS_AT50    = 622,
  parameter int STOP50     = 626,
  parameter int WIN_LO50   = 622,
  parameter int TMO50      = 628,
  parameter int TMO_LONG50 = 722,
  parameter int SIDE_SHIFT = 100
) (
  input  logic             sys60_i,
  output logic [CNT_W-1:0] vs_at_o,
  output logic [CNT_W-1:0] stop_o,
  output logic [CNT_W-1:0] win_lo_o,
  output logic [CNT_W-1:0] tmo_o,
  output logic [CNT_W-1:0] tmo_long_o
);
  localparam logic [CNT_W-1:0] A50 = CNT_W'(VS_AT50);
  localparam logic [CNT_W-1:0] S50 = CNT_W'(STOP50);
  localparam logic [CNT_W-1:0] L50 = CNT_W'(WIN_LO50);
  localparam logic [CNT_W-1:0] T50 = CNT_W'(TMO50);
  localparam logic [CNT_W-1:0] G50 = CNT_W'(TMO_LONG50);
  localparam logic [CNT_W-1:0] A60 = CNT_W'(VS_AT50 - SIDE_SHIFT);
  localparam logic [CNT_W-1:0] S60 = CNT_W'(STOP50 - SIDE_SHIFT);
  localparam logic [CNT_W-1:0] L60 = CNT_W'(WIN_LO50 - SIDE_SHIFT);
  localparam logic [CNT_W-1:0] T60 = CNT_W'(TMO50 - SIDE_SHIFT);
  localparam logic [CNT_W-1:0] G60 = CNT_W'(TMO_LONG50 - SIDE_SHIFT);

  always_comb begin
    if (sys60_i) begin
      vs_at_o    = A60;
      stop_o     = S60;
      win_lo_o   = L60;
      tmo_o      = T60;
      tmo_long_o = G60;
    end else begin
      vs_at_o    = A50;
      stop_o     = S50;
      win_lo_o   = L50;
      tmo_o      = T50;
      tmo_long_o = G50;
    end
  end
endmodule

// File: rtl/vfield_pulse.sv
module vfield_pulse #(
  parameter int VS_LEN = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic start_i,
  output logic pulse_o
);
  localparam int LW = (VS_LEN > 1) ? $clog2(VS_LEN) : 1;
  localparam logic [LW-1:0] LOAD = LW'(VS_LEN - 1);

  logic [LW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_o <= 1'b0;
      left    <= '0;
    end else if (start_i) begin
      pulse_o <= 1'b1;
      left    <= LOAD;
    end else if (en_i && pulse_o) begin
      if (left == '0) pulse_o <= 1'b0;
      else            left    <= left - 1'b1;
    end
  end

  // R5
  pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
    (pulse_o && en_i && !start_i && left == '0) |=> !pulse_o);

  // R5
  pulse_start_chk: assert property (@(posedge clk) disable iff (rst)
    start_i |=> pulse_o);
endmodule

// File: rtl/vfield_ctrl.sv
module vfield_ctrl #(
  parameter int CNT_W      = 10,
  parameter int VS_LEN     = 6,
  parameter int BRANCH_AT  = 488,
  parameter int VS_AT50    = 622,
  parameter int STOP50     = 626,
  parameter int WIN_LO50   = 622,
  parameter int TMO50      = 628,
  parameter int TMO_LONG50 = 722,
  parameter int SIDE_SHIFT = 100,
  parameter int SPLIT      = 575
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en2h_i,
  input  logic             vsync_in_i,
  input  logic             locked_i,
  input  logic             forced_i,
  input  logic             force60_i,
  input  logic [1:0]       norm_i,
  output logic             vsync_o,
  output logic [CNT_W-1:0] line_cnt_o,
  output logic             sys60_o
);
  import vfield_pkg::*;

  localparam logic [CNT_W-1:0] BR_CNT  = CNT_W'(BRANCH_AT);
  localparam logic [CNT_W-1:0] SPL_CNT = CNT_W'(SPLIT);
  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(TMO_LONG50 - 1);

  phase_t           phase;
  logic [CNT_W-1:0] cnt, cnt_inc, cap;
  logic             pend, sys60;
  logic             rise, in_win, take, tmo_hit, hold_end, clr, pulse_go;
  logic [CNT_W-1:0] vs_at, stop_at, win_lo, tmo, tmo_long, tmo_sel;

  vfield_edge u_edge (
    .clk    (clk),
    .rst    (rst),
    .sig_i  (vsync_in_i),
    .rise_o (rise)
  );

  vfield_limits #(
    .CNT_W      (CNT_W),
    .VS_AT50    (VS_AT50),
    .STOP50     (STOP50),
    .WIN_LO50   (WIN_LO50),
    .TMO50      (TMO50),
    .TMO_LONG50 (TMO_LONG50),
    .SIDE_SHIFT (SIDE_SHIFT)
  ) u_lim (
    .sys60_i    (sys60),
    .vs_at_o    (vs_at),
    .stop_o     (stop_at),
    .win_lo_o   (win_lo),
    .tmo_o      (tmo),
    .tmo_long_o (tmo_long)
  );

  assign cnt_inc = cnt + 1'b1;
  assign tmo_sel = (forced_i && locked_i) ? tmo_long : tmo;

  always_comb begin
    tmo_hit = 1'b0;
    if (en2h_i && !pend) begin
      case (phase)
        PH_WEAK: tmo_hit = (cnt_inc >= tmo);
        PH_NONE: tmo_hit = (cnt_inc >= tmo_sel);
        default: tmo_hit = 1'b0;
      endcase
    end
  end

  assign in_win   = (phase == PH_NONE) ||
                    (phase == PH_WEAK && cnt > win_lo && cnt < tmo);
  assign take     = rise && in_win && !pend && !tmo_hit;
  assign hold_end = en2h_i && !pend && (phase == PH_HOLD);
  assign clr      = (en2h_i && pend) || tmo_hit || hold_end;
  assign pulse_go = (en2h_i && pend) || tmo_hit ||
                    (en2h_i && phase == PH_STRONG && cnt_inc == vs_at);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_COUNT;
      cnt   <= '0;
      pend  <= 1'b0;
      cap   <= '0;
    end else begin
      if (take) begin
        pend <= 1'b1;
        cap  <= cnt;
      end
      if (clr) begin
        cnt   <= '0;
        phase <= PH_COUNT;
        if (en2h_i && pend) pend <= 1'b0;
      end else if (en2h_i) begin
        case (phase)
          PH_COUNT: begin
            cnt <= cnt_inc;
            if (cnt_inc == BR_CNT) begin
              if (norm_i == NORM_STRONG)    phase <= PH_STRONG;
              else if (norm_i == NORM_WEAK) phase <= PH_WEAK;
              else                          phase <= PH_NONE;
            end
          end
          PH_STRONG: begin
            cnt <= cnt_inc;
            if (cnt_inc >= stop_at) phase <= PH_HOLD;
          end
          PH_WEAK, PH_NONE: cnt <= cnt_inc;
          default: cnt <= cnt;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sys60 <= 1'b0;
    end else if (clr) begin
      if (forced_i)                sys60 <= force60_i;
      else if (en2h_i && pend)     sys60 <= (cap < SPL_CNT);
    end
  end

  vfield_pulse #(.VS_LEN(VS_LEN)) u_pulse (
    .clk     (clk),
    .rst     (rst),
    .en_i    (en2h_i),
    .start_i (pulse_go),
    .pulse_o (vsync_o)
  );

  assign line_cnt_o = cnt;
  assign sys60_o    = sys60;

  // R2
  count_phase_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_COUNT) |-> (cnt < BR_CNT));

  // R2
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en2h_i |=> $stable(cnt));

  // R6
  pend_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (pend && en2h_i) |=> (cnt == '0 && !pend));

  // R8
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= MAX_CNT);

  // R9
  sys_change_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sys60) |-> (cnt == '0));

  // R4
  strong_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_STRONG || phase == PH_HOLD) |-> !pend);
endmodule

// File: tb/vfield_ctrl_test.sv
module vfield_ctrl_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en2h = 1'b0, vs_in = 1'b0, locked = 1'b0, forced = 1'b0, f60 = 1'b0;
  logic [1:0] norm = 2'b00;
  logic       vs_out, sys60;
  logic [9:0] lc;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  logic exp_sys = 1'b0;

  vfield_ctrl uut (
    .clk(clk), .rst(rst), .en2h_i(en2h), .vsync_in_i(vs_in),
    .locked_i(locked), .forced_i(forced), .force60_i(f60), .norm_i(norm),
    .vsync_o(vs_out), .line_cnt_o(lc), .sys60_o(sys60)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: run hung, actual=%0d expected<190000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total = total + 1;
    if (act != exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick_en;
    @(negedge clk) en2h = 1'b1;
    @(negedge clk) en2h = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_vs;
    @(negedge clk) vs_in = 1'b1;
    @(negedge clk);
    @(negedge clk) vs_in = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_to(input int target);
    for (int i = 0; i < 900 && lc != 10'(target); i++) tick_en;
  endtask

  function automatic int exp_peak(input logic s60, input logic [1:0] nm, input logic fo,
                                  input logic lk, input logic has, input int s);
    int sh = s60 ? 100 : 0;
    int to;
    if (nm == 2'b00) return 626 - sh;
    if (nm == 2'b01) begin
      to = 628 - sh;
      if (has && s > 622 - sh && s < to) return s;
      return to - 1;
    end
    to = (fo && lk) ? 722 - sh : 628 - sh;
    if (has && s >= 488 && s < to) return s;
    return to - 1;
  endfunction

  function automatic logic exp_next_sys(input logic cur, input logic [1:0] nm, input logic fo,
                                        input logic sel, input logic has, input int s,
                                        input int peak);
    if (fo) return sel;
    if (nm != 2'b00 && has && s == peak) return (s < 575);
    return cur;
  endfunction

  task automatic run_field(input string req, input logic [1:0] nm, input logic fo,
                           input logic lk, input logic sel, input logic has, input int s);
    int pk = 0;
    int ep;
    logic done = 1'b0;
    @(negedge clk);
    norm = nm; forced = fo; locked = lk; f60 = sel;
    ep = exp_peak(exp_sys, nm, fo, lk, has, s);
    for (int i = 0; i < 900; i++) begin
      tick_en;
      if (lc == 10'd0) break;
      if (int'(lc) > pk) pk = int'(lc);
      if (has && !done && int'(lc) == s) begin
        pulse_vs;
        done = 1'b1;
      end
    end
    chk({req, " peak count"}, pk, ep);
    exp_sys = exp_next_sys(exp_sys, nm, fo, sel, has, s, ep);
    chk({req, " R9 system"}, int'(sys60), int'(exp_sys));
    chk({req, " count cleared"}, int'(lc), 0);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 count", int'(lc), 0);
    chk("R1 vsync", int'(vs_out), 0);
    chk("R1 system", int'(sys60), 0);

    // R2 hold without enable, count with enable, early sync ignored
    repeat (5) @(negedge clk);
    chk("R2 hold", int'(lc), 0);
    tick_en; tick_en; tick_en;
    chk("R2 advance", int'(lc), 3);
    pulse_vs;
    tick_en;
    chk("R2 early sync ignored", int'(lc), 4);

    // R4 R5 strong branch generated pulse timing (50 Hz)
    norm = 2'b00;
    run_to(621);
    chk("R3 strong branch reached 621", int'(lc), 621);
    chk("R4 no pulse before 622", int'(vs_out), 0);
    pulse_vs;
    tick_en;
    chk("R4 pulse at 622", int'(vs_out), 1);
    chk("R4 input sync ignored", int'(lc), 622);
    tick_en; tick_en; tick_en; tick_en;
    chk("R4 stop at 626", int'(lc), 626);
    tick_en;
    chk("R4 cleared after stop", int'(lc), 0);
    chk("R5 pulse still high at sixth enable", int'(vs_out), 1);
    tick_en;
    chk("R5 pulse low after six enables", int'(vs_out), 0);

    // R7 weak branch timeout pulse (50 Hz)
    run_field("R7 weak timeout", 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 0);
    chk("R7 R5 pulse at timeout clear", int'(vs_out), 1);
    run_to(5);
    chk("R5 pulse high at count 5", int'(vs_out), 1);
    tick_en;
    chk("R5 pulse low at count 6", int'(vs_out), 0);

    // R6 R9 no-norm sync at 525 -> 60 Hz, then R8 forced+locked long timeout
    run_field("R6 no-norm accept", 2'b10, 1'b0, 1'b0, 1'b0, 1'b1, 525);
    run_field("R8 forced locked timeout", 2'b11, 1'b1, 1'b1, 1'b1, 1'b0, 0);
    run_field("R7 weak in window 60", 2'b01, 1'b0, 1'b0, 1'b0, 1'b1, 525);
    run_field("R7 weak outside window 60", 2'b01, 1'b0, 1'b0, 1'b0, 1'b1, 500);

    // R10 input edge together with the timeout enable (60 Hz weak, timeout 528)
    norm = 2'b01; forced = 1'b0; locked = 1'b0;
    run_to(527);
    chk("R10 at 527", int'(lc), 527);
    @(negedge clk) begin en2h = 1'b1; vs_in = 1'b1; end
    @(negedge clk) begin en2h = 1'b0; end
    @(negedge clk) vs_in = 1'b0;
    chk("R10 cleared once", int'(lc), 0);
    tick_en;
    chk("R10 no second clear", int'(lc), 1);
    chk("R10 system kept", int'(sys60), 1);
    run_to(0);

    // random fields
    for (int k = 0; k < 30; k++) begin
      logic [1:0] nm = 2'($urandom_range(0, 3));
      logic fo = ($urandom_range(0, 3) == 0);
      logic lk = $urandom_range(0, 1) == 1;
      logic sl = $urandom_range(0, 1) == 1;
      logic hs = $urandom_range(0, 4) != 0;
      int   s  = (k % 3 == 0) ? int'($urandom_range(300, 725))
                              : (exp_sys ? int'($urandom_range(500, 630))
                                         : int'($urandom_range(600, 725)));
      run_field("R3 R7 R8 random", nm, fo, lk, sl, hs, s);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule